// File: doc/BRIEF.md
# Branch Target Buffer with Vacancy-Aliased State Zero

This block is a small direct-mapped branch target buffer for a fetch pipeline. Each line holds a valid flag, an address tag, a predicted target and a 2-bit prediction state. The fetch stage presents an address on the lookup side. The block answers in the same cycle with a hit flag, a taken/not-taken guess and the stored target. The execute stage reports each resolved branch on the update side with its address, real outcome and real target.

State zero is treated as a vacant line. A branch that resolves taken while it has no line, or while its line has fallen to state zero, is written straight into the strongest taken state. Lines in states 1 to 3 act as a saturating up/down counter. An execute stage that still holds the branch in flight can set the bypass flag and supply that branch's state directly. In that case the update uses the supplied state and behaves as a plain saturating counter, so a taken outcome from state zero reaches state 1. This is how back-to-back runs of a tight loop behave.

Updates are registered once and written one cycle later. During that pending cycle, a lookup sees the new contents only when the pending update came through the bypass path.

Top module: `btb_asym_alloc`

## Requirements
- R1: A lookup with no valid line whose tag matches returns hit=0, taken=0 and target=0.
- R2: A non-bypass taken update that finds no matching valid line writes the line with the new tag and target in state 3, replacing any line with another tag at that index. The next lookup of that branch hits and predicts taken.
- R3: A line that reaches state 0 is invalidated, so its lookups miss. A later non-bypass taken update for that branch re-allocates it in state 3, so it still predicts taken after one further not-taken outcome.
- R4: A hitting lookup predicts taken when the line's state is 2 or 3 and not taken when it is 1.
- R5: A non-bypass update that hits a valid line steps the state by +1 when taken (saturating at 3) and by -1 when not taken.
- R6: With up_bypass=1 the update uses up_byp_state (0..3) as the current state. It steps by +1 saturating at 3 when taken (0 goes to 1) and by -1 saturating at 0 when not taken. The line is written valid with the update's tag, or invalid if the result is 0.
- R7: A non-bypass not-taken update that finds no matching valid line changes nothing. It neither allocates nor disturbs a line of another tag at that index.
- R8: An update strobed on clock edge k is written on edge k+1. A lookup to the same index between those edges sees the old contents when up_bypass was 0, and the new contents when up_bypass was 1.
- R9: Reset clears every valid flag, so every lookup misses after reset.
- R10: The index is address bits [4:1] and the tag is bits [15:5]. Bit 0 is ignored, and two addresses that differ only in tag bits compete for one line.
- R11: A hitting lookup returns the up_target of the most recent update that wrote that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 16 | Fetch address to look up |
| lk_hit | output | 1 | Valid line with matching tag found |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 16 | Predicted target, zero on a miss |
| up_valid | input | 1 | Update strobe |
| up_addr | input | 16 | Resolved branch address |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | 16 | Actual branch target |
| up_bypass | input | 1 | Use up_byp_state instead of the stored state |
| up_byp_state | input | 2 | State of the in-flight branch, used when up_bypass=1 |

## Verification
The embedded properties check, on every cycle, the following:
- A miss never predicts taken.
- No valid line holds state zero.
- A fresh allocation is visible as a taken hit right after it is written.
- A bypassed taken update from state zero shows up as a not-taken hit.
- Reset leaves the buffer empty.

Only the bench's scenarios can show the rest:
- Counter saturation over long runs.
- Re-allocation into state 3 after a line decays to vacancy.
- Tag conflicts at one index, and bit 0 being ignored.
- Which contents a lookup sees during the pending cycle.

A reference model in the bench tracks all of these against a mix of random update and lookup traffic.

// File: rtl/btb_asym_alloc.sv
module btb_asym_alloc #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int TGT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [TGT_W-1:0]  lk_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [TGT_W-1:0]  up_target,
  input  logic              up_bypass,
  input  logic [1:0]        up_byp_state
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - 1;

  logic [LINES-1:0] v_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [TGT_W-1:0] tgt_q [LINES];
  logic [1:0]       st_q  [LINES];

  logic              p_vld, p_taken, p_byp;
  logic [ADDR_W-1:0] p_addr;
  logic [TGT_W-1:0]  p_tgt;
  logic [1:0]        p_bst;

  logic unused_bit0;
  assign unused_bit0 = lk_addr[0] ^ p_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) p_vld <= 1'b0;
    else        p_vld <= up_valid;
    if (up_valid) begin
      p_addr  <= up_addr;
      p_taken <= up_taken;
      p_tgt   <= up_target;
      p_byp   <= up_bypass;
      p_bst   <= up_byp_state;
    end
  end

  wire [IDX_W-1:0] p_idx = p_addr[IDX_W:1];
  wire [TAG_W-1:0] p_tag = p_addr[ADDR_W-1:IDX_W+1];
  wire             mem_match = v_q[p_idx] && (tag_q[p_idx] == p_tag);
  wire [1:0]       cur_st = p_byp ? p_bst : (mem_match ? st_q[p_idx] : 2'd0);

  logic [1:0] nxt_st;
  logic       wr_en, wr_v;

  always_comb begin
    if (p_taken) begin
      if (!p_byp && cur_st == 2'd0) nxt_st = 2'd3;
      else if (cur_st == 2'd3)      nxt_st = 2'd3;
      else                          nxt_st = cur_st + 2'd1;
      wr_en = p_vld;
    end else begin
      nxt_st = (cur_st == 2'd0) ? 2'd0 : cur_st - 2'd1;
      wr_en  = p_vld && (p_byp || mem_match);
    end
    wr_v = (nxt_st != 2'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else if (wr_en) v_q[p_idx] <= wr_v;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[p_idx] <= p_tag;
      tgt_q[p_idx] <= p_tgt;
      st_q[p_idx]  <= nxt_st;
    end
  end

  wire [IDX_W-1:0] lk_idx = lk_addr[IDX_W:1];
  wire [TAG_W-1:0] lk_tag = lk_addr[ADDR_W-1:IDX_W+1];
  wire             fwd    = p_vld && p_byp && (p_idx == lk_idx);

  always_comb begin
    if (fwd) begin
      lk_hit   = wr_v && (p_tag == lk_tag);
      lk_taken = lk_hit && nxt_st[1];
      lk_target = lk_hit ? p_tgt : '0;
    end else begin
      lk_hit   = v_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
      lk_taken = lk_hit && st_q[lk_idx][1];
      lk_target = lk_hit ? tgt_q[lk_idx] : '0;
    end
  end

  p_miss_not_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!lk_taken && lk_target == '0));

  p_alloc_strong_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p_vld && !p_byp && p_taken && !mem_match) && !p_vld &&
     lk_addr[ADDR_W-1:1] == $past(p_addr[ADDR_W-1:1])) |-> (lk_hit && lk_taken));

  p_bypass_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(p_vld && p_byp && p_taken && p_bst == 2'd0) && !p_vld &&
     lk_addr[ADDR_W-1:1] == $past(p_addr[ADDR_W-1:1])) |-> (lk_hit && !lk_taken));

  p_reset_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (v_q == '0));

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    p_vacant_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      v_q[g] |-> (st_q[g] != 2'd0));
  end
endmodule

// File: tb/test_btb_asym_alloc.sv
module test_btb_asym_alloc;
  logic clk = 0, rst_n = 0;
  logic [15:0] lk_addr = 0, up_addr = 0, up_target = 0;
  logic lk_hit, lk_taken;
  logic [15:0] lk_target;
  logic up_valid = 0, up_taken = 0, up_bypass = 0;
  logic [1:0] up_byp_state = 0;

  btb_asym_alloc i_btb_asym_alloc (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit         mv  [16];
  logic [10:0] mtag[16];
  logic [15:0] mtgt[16];
  logic [1:0]  mst [16];

  function automatic logic [15:0] mk(input int t, input int i, input int b0);
    return {t[10:0], i[3:0], b0[0]};
  endfunction

  task automatic model_upd(input logic [15:0] a, input bit tk, input logic [15:0] tg,
                           input bit byp, input logic [1:0] bs);
    int i = a[4:1];
    bit m = mv[i] && mtag[i] == a[15:5];
    logic [1:0] c = byp ? bs : (m ? mst[i] : 2'd0);
    logic [1:0] n;
    if (tk) n = (!byp && c == 0) ? 2'd3 : (c == 3 ? 2'd3 : c + 2'd1);
    else    n = (c == 0) ? 2'd0 : c - 2'd1;
    if (tk || byp || m) begin
      mv[i] = (n != 0); mtag[i] = a[15:5]; mtgt[i] = tg; mst[i] = n;
    end
  endtask

  task automatic check(input logic [15:0] a, input string req);
    int i = a[4:1];
    bit eh = mv[i] && mtag[i] == a[15:5];
    bit et = eh && mst[i][1];
    logic [15:0] eg = eh ? mtgt[i] : 16'h0;
    lk_addr = a;
    #1;
    n_chk++;
    if (lk_hit !== eh || lk_taken !== et || lk_target !== eg) begin
      n_bad++;
      $display("FAIL %s addr=%h actual hit=%b taken=%b tgt=%h expected hit=%b taken=%b tgt=%h",
               req, a, lk_hit, lk_taken, lk_target, eh, et, eg);
    end
  endtask

  task automatic expect3(input logic [15:0] a, input bit h, input bit t, input string req);
    lk_addr = a;
    #1;
    n_chk++;
    if (lk_hit !== h || lk_taken !== t) begin
      n_bad++;
      $display("FAIL %s addr=%h actual hit=%b taken=%b expected hit=%b taken=%b",
               req, a, lk_hit, lk_taken, h, t);
    end
  endtask

  task automatic upd(input logic [15:0] a, input bit tk, input logic [15:0] tg,
                     input bit byp = 0, input logic [1:0] bs = 0);
    @(negedge clk);
    up_valid = 1; up_addr = a; up_taken = tk; up_target = tg;
    up_bypass = byp; up_byp_state = bs;
    @(negedge clk);
    up_valid = 0;
    @(negedge clk);
    model_upd(a, tk, tg, byp, bs);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] A, B;
    for (int i = 0; i < 16; i++) mv[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(mk(0, 3, 0), "R9");
    check(mk(5, 9, 1), "R1");

    A = mk(2, 6, 0); B = mk(7, 6, 0);
    upd(A, 1, 16'h1200);
    check(A, "R2");
    expect3(A, 1, 1, "R2");
    check(A | 16'h1, "R10");
    upd(A, 0, 16'h1200); check(A, "R5");
    upd(A, 0, 16'h1200); expect3(A, 1, 0, "R4");
    upd(A, 1, 16'h1300); expect3(A, 1, 1, "R5");
    repeat (3) upd(A, 1, 16'h1300);
    upd(A, 0, 16'h1300); expect3(A, 1, 1, "R5");
    upd(A, 0, 16'h1300); upd(A, 0, 16'h1300);
    expect3(A, 0, 0, "R3");
    upd(A, 1, 16'h1400); expect3(A, 1, 1, "R3");
    upd(A, 0, 16'h1400); expect3(A, 1, 1, "R3");
    check(A, "R11");
    upd(B, 0, 16'h2000); check(A, "R7"); expect3(B, 0, 0, "R7");
    upd(B, 1, 16'h2100); check(B, "R10"); expect3(A, 0, 0, "R10");
    upd(A, 1, 16'h5000, 1, 2'd0); expect3(A, 1, 0, "R6");
    upd(A, 1, 16'h5000, 1, 2'd3); expect3(A, 1, 1, "R6");
    upd(A, 0, 16'h5000, 1, 2'd1); expect3(A, 0, 0, "R6");
    upd(mk(1, 11, 0), 0, 16'h0, 0, 0); expect3(mk(1, 11, 0), 0, 0, "R7");

    // R8: pending-cycle visibility
    @(negedge clk);
    up_valid = 1; up_addr = mk(3, 12, 0); up_taken = 1; up_target = 16'h7777; up_bypass = 0;
    @(negedge clk); up_valid = 0;
    expect3(mk(3, 12, 0), 0, 0, "R8");
    @(negedge clk); model_upd(mk(3, 12, 0), 1, 16'h7777, 0, 0);
    expect3(mk(3, 12, 0), 1, 1, "R8");
    up_valid = 1; up_addr = mk(4, 13, 0); up_taken = 1; up_target = 16'h8888;
    up_bypass = 1; up_byp_state = 2'd2;
    @(negedge clk); up_valid = 0; up_bypass = 0;
    expect3(mk(4, 13, 0), 1, 1, "R8");
    @(negedge clk); model_upd(mk(4, 13, 0), 1, 16'h8888, 1, 2'd2);
    check(mk(4, 13, 0), "R8");

    for (int k = 0; k < 1500; k++) begin
      logic [15:0] a = mk($urandom_range(0, 2), $urandom_range(0, 15), $urandom_range(0, 1));
      bit byp = ($urandom_range(0, 7) == 0);
      upd(a, $urandom_range(0, 1), 16'($urandom), byp, 2'($urandom));
      check(a, "R4");
      check(mk($urandom_range(0, 2), $urandom_range(0, 15), 0), "R11");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule